// File: doc/BRIEF.md
# Memory-Mapped Machine Timer Comparator

This block keeps a free-running time counter and a compare register, each twice as wide as the data bus. With the default 32-bit bus both are 64 bits wide, so a 32-bit core can reach every value as a low and a high word. An input qualifies each counter step, so the count rate follows whatever timebase the chip supplies. Software reads and writes both registers through a small word-wide bus. That bus takes a request in one cycle and returns read data on the next clock. It never stalls, so it has no ready signal and no back-pressure.

The block drives a level-sensitive machine timer interrupt. The interrupt comes from an unsigned greater-or-equal comparison of the time value against the compare value. There is no acknowledge. The line drops only when the comparison stops holding. That happens when software writes a compare value above the current time, or when the counter wraps past its top.

Top module: `mtimer_cmp`

## Requirements
- R1: When `tick_en` is high and no bus write targets the time counter in that cycle, the time counter advances by exactly one at the clock edge. A carry from the low word propagates into the high word. When `tick_en` is low and no write targets the counter, it holds its value.
- R2: A bus write to one half of the time counter replaces that half with `bus_wdata` and keeps the other half. The write wins over the increment, so no tick is applied in that cycle.
- R3: A bus write to one half of the compare register replaces that half and keeps the other half. Without such a write, the compare register holds its value.
- R4: After reset, the time counter is zero, the compare register is all ones, and `timer_irq`, `bus_rvalid` and `bus_rdata` are all zero.
- R5: At each clock edge, `timer_irq` takes the result of an unsigned (time >= compare) test on the register values before that edge. The interrupt therefore follows any register change one clock later. The test is unsigned, so a top bit of one does not count as negative.
- R6: Once asserted, `timer_irq` stays high through reads, idle cycles and further ticks. It falls only after the compare value is moved above the time value, or after the time counter wraps below the compare value.
- R7: The word map decodes byte address bits [3:2] with bits [1:0] equal to zero. 0x0 is the compare low word, 0x4 the compare high word, 0x8 the time low word and 0xC the time high word. A read request (`bus_valid` high, `bus_we` low) returns that register's value, as sampled in the request cycle, on `bus_rdata` one clock later. `bus_rvalid` is high for exactly that cycle. `bus_rvalid` is low after a write request or an idle cycle.
- R8: Any address with bits [1:0] not zero, or at or above 0x10, is unmapped. A read of it returns zero with `bus_rvalid` high. A write to it changes no register.
- R9: The time counter wraps from all ones to zero on a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Time counter step qualifier |
| bus_valid | input | 1 | Bus request present this cycle |
| bus_we | input | 1 | Request is a write (1) or a read (0) |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, one clock after the request |
| bus_rvalid | output | 1 | Marks the cycle in which bus_rdata answers a read |
| timer_irq | output | 1 | Registered machine timer interrupt level |

## Verification
The bench builds the block with an 8-bit bus, which gives a 16-bit counter and compare register, and a 5-bit address. The narrow width makes it practical to sweep every pairing of a boundary-value set for time and compare. That set includes values on both sides of the half-word carry and of the sign bit. The narrow width also puts counter wrap and carry propagation within a few ticks. The 5-bit address exposes both unaligned offsets and offsets past the map, so unmapped reads and writes can be probed.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

  typedef enum logic [1:0] {
    SEL_CMP_LO  = 2'd0,
    SEL_CMP_HI  = 2'd1,
    SEL_TIME_LO = 2'd2,
    SEL_TIME_HI = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
  } dec_t;

  localparam int unsigned NUM_WORDS = 4;

endpackage

// File: rtl/mtc_decode.sv
module mtc_decode
  import mtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                 bus_valid,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic [NUM_WORDS-1:0] wr_strobe,
  output logic                 rd_req,
  output dec_t                 dec
);

  localparam int unsigned MAP_BYTES_LOG2 = 4;

  logic aligned;
  logic in_range;

  always_comb begin
    aligned  = (bus_addr[1:0] == 2'b00);
    in_range = ((bus_addr >> MAP_BYTES_LOG2) == '0);
    dec.hit  = aligned && in_range;
    dec.sel  = reg_sel_e'(bus_addr[3:2]);
    rd_req   = bus_valid && !bus_we;
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_wstb
    assign wr_strobe[g] = bus_valid && bus_we && dec.hit && (dec.sel == reg_sel_e'(g));
  end

endmodule

// File: rtl/mtc_wreg.sv
module mtc_wreg #(
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned W       = 2 * BUS_W,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter bit           COUNT   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [BUS_W-1:0] wdata,
  output logic [W-1:0]     q
);

  logic [W-1:0] stepped;
  logic [W-1:0] nxt;

  if (COUNT) begin : g_count
    assign stepped = inc ? (q + W'(1)) : q;
  end else begin : g_hold
    logic unused_inc;
    assign unused_inc = inc;
    assign stepped    = q;
  end

  always_comb begin
    if (wr_lo)      nxt = {q[W-1:BUS_W], wdata};
    else if (wr_hi) nxt = {wdata, q[BUS_W-1:0]};
    else            nxt = stepped;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= nxt;
  end

endmodule

// File: rtl/mtc_irq.sv
module mtc_irq #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] time_val,
  input  logic [W-1:0] cmp_val,
  output logic         irq
);

  logic reached;

  assign reached = (time_val >= cmp_val);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= reached;
  end

endmodule

// File: rtl/mtimer_cmp.sv
module mtimer_cmp
  import mtc_pkg::*;
#(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic              timer_irq
);

  localparam int unsigned CNT_W = 2 * BUS_W;
  localparam logic [CNT_W-1:0] CMP_RST = '1;
  localparam logic [CNT_W-1:0] TIME_RST = '0;

  logic [NUM_WORDS-1:0] wr_strobe;
  logic                 rd_req;
  dec_t                 dec;
  logic [CNT_W-1:0]     time_q;
  logic [CNT_W-1:0]     cmp_q;
  logic [BUS_W-1:0]     rd_mux;

  mtc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .wr_strobe (wr_strobe),
    .rd_req    (rd_req),
    .dec       (dec)
  );

  mtc_wreg #(.BUS_W(BUS_W), .W(CNT_W), .RST_VAL(TIME_RST), .COUNT(1'b1)) u_time (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (tick_en),
    .wr_lo (wr_strobe[SEL_TIME_LO]),
    .wr_hi (wr_strobe[SEL_TIME_HI]),
    .wdata (bus_wdata),
    .q     (time_q)
  );

  mtc_wreg #(.BUS_W(BUS_W), .W(CNT_W), .RST_VAL(CMP_RST), .COUNT(1'b0)) u_cmp (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (1'b0),
    .wr_lo (wr_strobe[SEL_CMP_LO]),
    .wr_hi (wr_strobe[SEL_CMP_HI]),
    .wdata (bus_wdata),
    .q     (cmp_q)
  );

  mtc_irq #(.W(CNT_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .time_val (time_q),
    .cmp_val  (cmp_q),
    .irq      (timer_irq)
  );

  always_comb begin
    rd_mux = '0;
    if (dec.hit) begin
      unique case (dec.sel)
        SEL_CMP_LO:  rd_mux = cmp_q[BUS_W-1:0];
        SEL_CMP_HI:  rd_mux = cmp_q[CNT_W-1:BUS_W];
        SEL_TIME_LO: rd_mux = time_q[BUS_W-1:0];
        SEL_TIME_HI: rd_mux = time_q[CNT_W-1:BUS_W];
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 2 * BUS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rvalid,
  input logic              timer_irq,
  input logic [CNT_W-1:0]  time_val,
  input logic [CNT_W-1:0]  cmp_val
);

  logic any_wr;
  assign any_wr = bus_valid && bus_we;

  // R1: a tick with no bus write steps the counter by one
  assert_tick_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !any_wr) |=> (time_val == CNT_W'($past(time_val) + CNT_W'(1))));

  // R1: no tick and no write leaves the counter alone
  assert_time_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !any_wr) |=> $stable(time_val));

  // R3: the compare register moves only on a write
  assert_cmp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> $stable(cmp_val));

  // R5: the interrupt follows the previous cycle's unsigned compare
  assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (timer_irq == ($past(time_val) >= $past(cmp_val))));

  // R7: read data is flagged exactly one clock after a read request
  assert_rvalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bus_rvalid == $past(bus_valid && !bus_we)));

  // R8: a write to an unmapped address leaves both registers alone
  assert_unmapped_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && !tick_en && ((bus_addr[1:0] != 2'b00) || ((bus_addr >> 4) != '0)))
      |=> ($stable(cmp_val) && $stable(time_val)));

endmodule

bind mtimer_cmp mtc_checker #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .CNT_W(2 * BUS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .bus_valid  (bus_valid),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_rvalid (bus_rvalid),
  .timer_irq  (timer_irq),
  .time_val   (time_q),
  .cmp_val    (cmp_q)
);

// File: tb/mtimer_cmp_test.sv
module mtimer_cmp_test;

  localparam int unsigned BW      = 8;
  localparam int unsigned AW      = 5;
  localparam int unsigned CW      = 2 * BW;
  localparam time         CLK_PER = 10ns;

  localparam logic [AW-1:0] A_CLO = 5'h00;
  localparam logic [AW-1:0] A_CHI = 5'h04;
  localparam logic [AW-1:0] A_TLO = 5'h08;
  localparam logic [AW-1:0] A_THI = 5'h0C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic          timer_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PER / 2) clk = ~clk;

  mtimer_cmp #(.BUS_W(BW), .ADDR_W(AW)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .bus_valid  (bus_valid),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .timer_irq  (timer_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [BW-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [BW-1:0] d, output logic v);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
    v = bus_rvalid;
  endtask

  task automatic rd16(input logic [AW-1:0] lo_a, output logic [CW-1:0] v);
    logic [BW-1:0] lo, hi;
    logic          ok;
    rd(lo_a, lo, ok);
    rd(lo_a + AW'(4), hi, ok);
    v = {hi, lo};
  endtask

  task automatic set_time(input logic [CW-1:0] v);
    wr(A_TLO, v[BW-1:0]);
    wr(A_THI, v[CW-1:BW]);
  endtask

  task automatic set_cmp(input logic [CW-1:0] v);
    wr(A_CLO, v[BW-1:0]);
    wr(A_CHI, v[CW-1:BW]);
  endtask

  function automatic logic [CW-1:0] pick(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h007F;
      3: return 16'h0080;
      4: return 16'h00FF;
      5: return 16'h0100;
      6: return 16'h7FFF;
      7: return 16'h8000;
      8: return 16'hFFFE;
      default: return 16'hFFFF;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired before the run completed");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] d;
    logic          v;
    logic [CW-1:0] r;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    check("R4 irq", timer_irq, 0);
    check("R4 rvalid", bus_rvalid, 0);
    check("R4 rdata", bus_rdata, 0);
    rd16(A_TLO, r); check("R4 time", r, 16'h0000);
    rd16(A_CLO, r); check("R4 cmp", r, 16'hFFFF);

    // R7 map and rvalid behaviour
    wr(A_CLO, 8'h3C); rd(A_CLO, d, v); check("R7 cmp lo", d, 8'h3C); check("R7 rvalid", v, 1);
    check("R7 rvalid drop", bus_rvalid, 1);
    @(negedge clk); check("R7 rvalid one cycle", bus_rvalid, 0);
    rd(A_CHI, d, v); check("R3 cmp hi kept", d, 8'hFF);
    wr(A_CHI, 8'hA5); check("R7 rvalid after write", bus_rvalid, 0);
    rd16(A_CLO, r); check("R3 cmp both halves", r, 16'hA53C);
    set_time(16'h5AC3); rd16(A_TLO, r); check("R7 time rw", r, 16'h5AC3);

    // R8 unmapped reads and writes
    for (int a = 0; a < 32; a++) begin
      if ((a % 4) != 0 || a >= 16) begin
        wr(AW'(a), 8'h99);
        rd(AW'(a), d, v);
        check($sformatf("R8 read 0x%0h", a), {d, 7'b0, v}, {8'h00, 7'b0, 1'b1});
      end
    end
    rd16(A_CLO, r); check("R8 cmp untouched", r, 16'hA53C);
    rd16(A_TLO, r); check("R8 time untouched", r, 16'h5AC3);

    // R5 unsigned sweep
    for (int ci = 0; ci < 10; ci++) begin
      set_cmp(pick(ci));
      for (int ti = 0; ti < 10; ti++) begin
        set_time(pick(ti));
        @(negedge clk);
        check($sformatf("R5 t=%0h c=%0h", pick(ti), pick(ci)), timer_irq,
              (pick(ti) >= pick(ci)) ? 1 : 0);
      end
    end

    // R5 one-clock latency, R6 level hold
    set_cmp(16'hFFFF); set_time(16'h0100); @(negedge clk);
    check("R5 idle low", timer_irq, 0);
    wr(A_CHI, 8'h00);
    check("R5 not yet", timer_irq, 0);
    @(negedge clk); check("R5 after one clock", timer_irq, 1);
    rd(A_TLO, d, v); rd(A_CLO, d, v); repeat (5) @(negedge clk);
    check("R6 held through reads", timer_irq, 1);
    tick_en = 1'b1; repeat (7) @(negedge clk); tick_en = 1'b0;
    check("R6 held through ticks", timer_irq, 1);
    wr(A_CLO, 8'h10); @(negedge clk); check("R6 lower cmp still set", timer_irq, 1);
    wr(A_CHI, 8'h02); check("R6 clear latency", timer_irq, 1);
    @(negedge clk); check("R6 cleared", timer_irq, 0);

    // R1 counting with carry
    set_time(16'h00F0);
    @(negedge clk); tick_en = 1'b1;
    repeat (40) @(negedge clk);
    tick_en = 1'b0;
    rd16(A_TLO, r); check("R1 40 ticks", r, 16'h0118);
    repeat (4) @(negedge clk);
    rd16(A_TLO, r); check("R1 hold without tick", r, 16'h0118);

    // R9 wrap clears the interrupt
    set_cmp(16'h0005); set_time(16'hFFFE); @(negedge clk);
    check("R9 pending before wrap", timer_irq, 1);
    tick_en = 1'b1; repeat (2) @(negedge clk); tick_en = 1'b0;
    @(negedge clk);
    check("R9 irq after wrap", timer_irq, 0);
    rd16(A_TLO, r); check("R9 wrapped", r, 16'h0000);

    // R2 write beats tick
    set_time(16'h12FF);
    @(negedge clk);
    tick_en = 1'b1; bus_valid = 1'b1; bus_we = 1'b1; bus_addr = A_TLO; bus_wdata = 8'h40;
    @(negedge clk);
    tick_en = 1'b0; bus_valid = 1'b0; bus_we = 1'b0;
    rd16(A_TLO, r); check("R2 low write wins", r, 16'h1240);
    set_time(16'h12FF);
    @(negedge clk);
    tick_en = 1'b1; bus_valid = 1'b1; bus_we = 1'b1; bus_addr = A_THI; bus_wdata = 8'h55;
    @(negedge clk);
    tick_en = 1'b0; bus_valid = 1'b0; bus_we = 1'b0;
    rd16(A_TLO, r); check("R2 high write wins", r, 16'h55FF);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule